// File: doc/BRIEF.md
# Jitter-Attenuating Elastic Store

This block smooths out line-side timing jitter. Two-bit line symbols (a positive-rail bit and a negative-rail bit) arrive as single-cycle write strobes whose spacing wanders. The block holds them in a circular store and hands them out on a read strobe that it makes itself by dividing the system clock. The system clock runs at eight times the nominal bit rate and is the only timing reference the block uses.

The read pace is set by a small state machine. In `ST_NOMINAL` a read strobe comes every 8 clocks. When the store gets within two entries of full, the machine moves to `ST_HURRY` and strobes every 7 clocks. When the store gets within two entries of empty, it moves to `ST_LINGER` and strobes every 9 clocks. Each of these nudges is one eighth of a bit. The machine returns to `ST_NOMINAL` once the fill level is back inside the guard band.

The store depth is selectable as 32 or 64 entries. On reset, on a depth change, or on re-enable, the store is recentred to half full. It then holds a steady latency of half the depth, counted in bits. Overflow and underflow set sticky flags, and each flag can raise a maskable interrupt. When the block is disabled it passes data straight through (`ST_PASS`).

Top module: `jas_elastic_buffer`

State transitions: any state goes to `ST_PASS` when `enable` is low. `ST_PASS` goes to `ST_NOMINAL` when `enable` rises. `ST_NOMINAL`, `ST_HURRY` and `ST_LINGER` each move to `ST_HURRY` when fill >= depth-2, to `ST_LINGER` when fill <= 2, and to `ST_NOMINAL` otherwise.

## Requirements
- R1: `deep_sel`=0 selects 32 entries and `deep_sel`=1 selects 64 entries. Each entry holds {pos,neg}. Reset, a change of `deep_sel`, or a rise of `enable` clears the store and sets the fill level to half the depth. The first half-depth read strobes after that therefore output {0,0}, and the written symbols follow in write order.
- R2: A write while the store is full and no read happens in the same cycle is dropped and sets `ovf_flag`.
- R3: A read strobe while the store is empty outputs `rd_pos`=0 and `rd_neg`=0 and sets `unf_flag`.
- R4: While the fill level is strictly between 2 and depth-2, read strobes are exactly 8 clocks apart. A read strobe is always one cycle wide.
- R5: While the fill level is at least depth-2, read strobes are 7 clocks apart.
- R6: While the fill level is at most 2, read strobes are 9 clocks apart.
- R7: Both flags stay set until a one-cycle `stat_rd` pulse clears them. A new event in the same cycle as `stat_rd` wins over the clear. A recentre (R1) also clears both flags.
- R8: `irq` = (`ovf_flag` & !`ovf_mask`) | (`unf_flag` & !`unf_mask`).
- R9: With `enable`=0, `rd_stb`, `rd_pos` and `rd_neg` repeat `wr_stb`, `wr_pos` and `wr_neg` one clock later, and neither flag can be set.
- R10: After reset, `rd_stb`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 8x the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = buffer and smooth, 0 = pass through |
| deep_sel | input | 1 | 0 = 32 entries, 1 = 64 entries |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_pos | input | 1 | Incoming positive-rail bit |
| wr_neg | input | 1 | Incoming negative-rail bit |
| stat_rd | input | 1 | Status read; clears both sticky flags |
| ovf_mask | input | 1 | 1 blocks the overflow interrupt |
| unf_mask | input | 1 | 1 blocks the underflow interrupt |
| rd_stb | output | 1 | One-cycle read strobe on the smoothed clock |
| rd_pos | output | 1 | Outgoing positive-rail bit |
| rd_neg | output | 1 | Outgoing negative-rail bit |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt from unmasked flags |

## Verification
The assertions check, on every cycle, that:
- the fill level never exceeds the selected depth;
- a dropped write leaves the write pointer unchanged;
- read strobes never fall on adjacent cycles, and the phase counter stays bounded;
- the sticky flags only rise after an event and hold until they are cleared;
- an empty read yields zeros;
- pass-through echoes the write strobe.

Only the bench scenarios can show the exact 7, 8 and 9 clock spacing, the half-depth latency and symbol order after a recentre for both depths, and the mask and clear sequencing across a full overflow-to-underflow swing.

// File: rtl/jas_pkg.sv
package jas_pkg;
    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_NOMINAL = 2'd1,
        ST_HURRY   = 2'd2,
        ST_LINGER  = 2'd3
    } pace_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } sym_t;
endpackage

// File: rtl/jas_store_mem.sv
module jas_store_mem
    import jas_pkg::*;
#(
    parameter int MAX_DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reinit,
    input  logic [$clog2(MAX_DEPTH):0]  depth,
    input  logic                        wr_en,
    input  sym_t                        wr_sym,
    input  logic                        rd_en,
    output sym_t                        rd_sym,
    output logic                        rd_empty,
    output logic                        ovf_evt,
    output logic                        unf_evt,
    output logic [$clog2(MAX_DEPTH):0]  fill
);
    localparam int PTR_W = $clog2(MAX_DEPTH);
    localparam int CNT_W = PTR_W + 1;

    sym_t             mem [MAX_DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] half;
    logic             do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                              input logic [CNT_W-1:0] d);
        return ({1'b0, p} == d - CNT_W'(1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign half     = depth >> 1;
    assign rd_empty = (fill == '0);
    assign do_rd    = rd_en && !rd_empty;
    assign do_wr    = wr_en && ((fill < depth) || do_rd);
    assign ovf_evt  = wr_en && !do_wr && !reinit;
    assign unf_evt  = rd_en && rd_empty && !reinit;
    assign rd_sym   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            for (int i = 0; i < MAX_DEPTH; i++) mem[i] <= '0;
            wr_ptr <= half[PTR_W-1:0];
            rd_ptr <= '0;
            fill   <= half;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr_sym;
                wr_ptr      <= bump(wr_ptr, depth);
            end
            if (do_rd) rd_ptr <= bump(rd_ptr, depth);
            fill <= fill + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        fill <= depth);
    assert_drop_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill == depth && !reinit) |=> $stable(wr_ptr));
endmodule

// File: rtl/jas_read_pacer.sv
module jas_read_pacer
    import jas_pkg::*;
#(
    parameter int OVS   = 8,
    parameter int GUARD = 2,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             reinit,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] depth,
    output logic             tick,
    output pace_state_t      state
);
    localparam int PH_W = $clog2(OVS + 1);

    pace_state_t     state_nx;
    logic [PH_W-1:0] ph, lim;
    logic            near_full, near_empty;

    assign near_full  = fill >= depth - CNT_W'(GUARD);
    assign near_empty = fill <= CNT_W'(GUARD);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PASS:    if (enable) state_nx = ST_NOMINAL;
            ST_NOMINAL,
            ST_HURRY,
            ST_LINGER: begin
                if (!enable)         state_nx = ST_PASS;
                else if (near_full)  state_nx = ST_HURRY;
                else if (near_empty) state_nx = ST_LINGER;
                else                 state_nx = ST_NOMINAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PASS;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_HURRY:  lim = PH_W'(OVS - 2);
            ST_LINGER: lim = PH_W'(OVS);
            default:   lim = PH_W'(OVS - 1);
        endcase
        tick = enable && !reinit && (state != ST_PASS) && (ph >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || reinit || state == ST_PASS || tick) ph <= '0;
        else                                              ph <= ph + PH_W'(1);
    end

    assert_no_double_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_W'(OVS));
endmodule

// File: rtl/jas_flag_unit.sv
module jas_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic reinit,
    input  logic ovf_evt,
    input  logic unf_evt,
    input  logic clr,
    input  logic ovf_mask,
    input  logic unf_mask,
    output logic ovf_flag,
    output logic unf_flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (ovf_evt)  ovf_flag <= 1'b1;
            else if (clr) ovf_flag <= 1'b0;
            if (unf_evt)  unf_flag <= 1'b1;
            else if (clr) unf_flag <= 1'b0;
        end
    end

    assign irq = (ovf_flag && !ovf_mask) || (unf_flag && !unf_mask);

    assert_ovf_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(ovf_evt));
    assert_unf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> $past(unf_evt));
    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr && !reinit) |=> ovf_flag);
    assert_unf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !clr && !reinit) |=> unf_flag);
endmodule

// File: rtl/jas_elastic_buffer.sv
module jas_elastic_buffer
    import jas_pkg::*;
#(
    parameter int MAX_DEPTH   = 64,
    parameter int SMALL_DEPTH = 32,
    parameter int OVS         = 8,
    parameter int GUARD       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic deep_sel,
    input  logic wr_stb,
    input  logic wr_pos,
    input  logic wr_neg,
    input  logic stat_rd,
    input  logic ovf_mask,
    input  logic unf_mask,
    output logic rd_stb,
    output logic rd_pos,
    output logic rd_neg,
    output logic ovf_flag,
    output logic unf_flag,
    output logic irq
);
    localparam int CNT_W = $clog2(MAX_DEPTH) + 1;

    logic [1:0]       cfg_q;
    logic             reinit, tick, empty, ovf_evt, unf_evt;
    logic [CNT_W-1:0] depth, fill;
    sym_t             rd_sym, wr_sym;
    pace_state_t      state;

    assign depth  = deep_sel ? CNT_W'(MAX_DEPTH) : CNT_W'(SMALL_DEPTH);
    assign reinit = rst_n && ({enable, deep_sel} != cfg_q);
    assign wr_sym = '{pos: wr_pos, neg: wr_neg};

    always_ff @(posedge clk) begin
        cfg_q <= {enable, deep_sel};
    end

    jas_store_mem #(.MAX_DEPTH(MAX_DEPTH)) mem_i (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .depth(depth),
        .wr_en(wr_stb && enable), .wr_sym(wr_sym), .rd_en(tick),
        .rd_sym(rd_sym), .rd_empty(empty), .ovf_evt(ovf_evt),
        .unf_evt(unf_evt), .fill(fill)
    );

    jas_read_pacer #(.OVS(OVS), .GUARD(GUARD), .CNT_W(CNT_W)) pacer_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .reinit(reinit),
        .fill(fill), .depth(depth), .tick(tick), .state(state)
    );

    jas_flag_unit flag_i (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .ovf_evt(ovf_evt),
        .unf_evt(unf_evt), .clr(stat_rd), .ovf_mask(ovf_mask),
        .unf_mask(unf_mask), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb <= 1'b0;
            rd_pos <= 1'b0;
            rd_neg <= 1'b0;
        end else if (!enable) begin
            rd_stb <= wr_stb;
            rd_pos <= wr_pos;
            rd_neg <= wr_neg;
        end else begin
            rd_stb <= tick;
            rd_pos <= tick && !empty && rd_sym.pos;
            rd_neg <= tick && !empty && rd_sym.neg;
        end
    end

    assert_bypass_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && wr_stb) |=> rd_stb);
    assert_empty_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && empty) |=> (rd_stb && !rd_pos && !rd_neg));
    assert_pass_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> state != ST_PASS);
endmodule

// File: tb/jas_elastic_buffer_tb_top.sv
module jas_elastic_buffer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0, enable = 1'b1, deep_sel = 1'b0;
    logic wr_stb = 1'b0, wr_pos = 1'b0, wr_neg = 1'b0;
    logic stat_rd = 1'b0, ovf_mask = 1'b0, unf_mask = 1'b0;
    logic rd_stb, rd_pos, rd_neg, ovf_flag, unf_flag, irq;

    int   checks = 0, fails = 0, cyc = 0;
    logic done = 1'b0, auto_wr = 1'b0;
    logic [1:0] last_sym;

    // Row: bit 16 = deep_sel, bits [2k+1:2k] = symbol k as {pos,neg}
    localparam logic [16:0] ROWS [4] = '{
        {1'b0, 16'hE4B1},
        {1'b1, 16'h1BD2},
        {1'b0, 16'h93C6},
        {1'b1, 16'h6F08}
    };

    always #10 clk = ~clk;

    jas_elastic_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .deep_sel(deep_sel),
        .wr_stb(wr_stb), .wr_pos(wr_pos), .wr_neg(wr_neg), .stat_rd(stat_rd),
        .ovf_mask(ovf_mask), .unf_mask(unf_mask), .rd_stb(rd_stb),
        .rd_pos(rd_pos), .rd_neg(rd_neg), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            if (rd_stb) last_sym = {rd_pos, rd_neg};
            wr_stb = auto_wr;
            wr_pos = ~wr_pos;
            wr_neg = 1'b1;
        end
    endtask

    task automatic measure(output int iv);
        iv = 0;
        for (int k = 0; k < 60; k++) begin
            run(1);
            if (rd_stb) break;
        end
        for (int k = 0; k < 60; k++) begin
            run(1);
            iv++;
            if (rd_stb) break;
        end
    endtask

    initial begin
        int iv;
        run(3);
        rst_n = 1'b1;
        run(1);
        // R10: outputs after reset
        check(!rd_stb && !ovf_flag && !unf_flag && !irq, "R10 reset state",
              {rd_stb, ovf_flag, unf_flag, irq}, 0);

        // R1 / R4: table of latency vectors
        foreach (ROWS[r]) begin
            logic [1:0] got [48];
            int h, rcnt, wcnt, last_rd, zeros_bad, pat_bad, gap_bad;
            enable = 1'b0;
            run(2);
            deep_sel = ROWS[r][16];
            enable = 1'b1;
            h = ROWS[r][16] ? 32 : 16;
            rcnt = 0; wcnt = 0; last_rd = -1; gap_bad = 0;
            for (int c = 0; c < 2000 && rcnt < h + 8; c++) begin
                @(negedge clk);
                if (rd_stb) begin
                    got[rcnt] = {rd_pos, rd_neg};
                    if (last_rd >= 0 && c - last_rd != 8) gap_bad++;
                    last_rd = c;
                    rcnt++;
                end
                wr_stb = (c % 8 == 3) && (wcnt < h + 12);
                if (wr_stb) begin
                    {wr_pos, wr_neg} = (wcnt < 8) ? ROWS[r][2*wcnt +: 2] : 2'b00;
                    wcnt++;
                end
            end
            wr_stb = 1'b0;
            zeros_bad = 0; pat_bad = 0;
            for (int i = 0; i < h; i++) if (got[i] != 2'b00) zeros_bad++;
            for (int i = 0; i < 8; i++) if (got[h+i] != ROWS[r][2*i +: 2]) pat_bad++;
            check(zeros_bad == 0, "R1 recentred head zeros", zeros_bad, 0);
            check(pat_bad == 0, "R1 latency half depth, order", pat_bad, 0);
            check(gap_bad == 0, "R4 nominal 8-clock spacing", gap_bad, 0);
        end

        // R2 / R5 / R8: overflow at depth 32
        deep_sel = 1'b0;
        auto_wr = 1'b1;
        run(60);
        check(ovf_flag, "R2 overflow sets flag", ovf_flag, 1);
        check(irq, "R8 irq from overflow", irq, 1);
        measure(iv);
        check(iv == 7, "R5 near-full spacing", iv, 7);
        ovf_mask = 1'b1;
        run(1);
        check(!irq, "R8 overflow masked", irq, 0);

        // R3 / R6 / R7: underflow
        auto_wr = 1'b0;
        run(400);
        check(unf_flag, "R3 underflow sets flag", unf_flag, 1);
        check(ovf_flag, "R7 overflow flag sticky", ovf_flag, 1);
        check(irq, "R8 irq from underflow", irq, 1);
        measure(iv);
        check(iv == 9, "R6 near-empty spacing", iv, 9);
        check(last_sym == 2'b00, "R3 empty read zeros", last_sym, 0);
        unf_mask = 1'b1;
        run(1);
        check(!irq, "R8 underflow masked", irq, 0);

        // R7: clear by status read
        auto_wr = 1'b1;
        run(16);
        auto_wr = 1'b0;
        run(2);
        stat_rd = 1'b1;
        run(1);
        stat_rd = 1'b0;
        check(!ovf_flag && !unf_flag, "R7 status read clears",
              {ovf_flag, unf_flag}, 0);

        // R7 / R1: recentre clears flags
        auto_wr = 1'b1;
        run(60);
        check(ovf_flag, "R2 overflow again", ovf_flag, 1);
        auto_wr = 1'b0;
        deep_sel = 1'b1;
        run(2);
        check(!ovf_flag && !unf_flag, "R7 recentre clears flags",
              {ovf_flag, unf_flag}, 0);

        // R9: pass-through
        enable = 1'b0;
        run(2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_stb = 1'b1;
            {wr_pos, wr_neg} = 2'(k);
            @(negedge clk);
            wr_stb = 1'b0;
            check(rd_stb && {rd_pos, rd_neg} == 2'(k), "R9 bypass echo",
                  {rd_stb, rd_pos, rd_neg}, {1'b1, 2'(k)});
            @(negedge clk);
            check(!rd_stb, "R9 bypass strobe width", rd_stb, 0);
        end
        auto_wr = 1'b1;
        run(100);
        auto_wr = 1'b0;
        run(1);
        check(!ovf_flag && !unf_flag, "R9 no flags in bypass",
              {ovf_flag, unf_flag}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule